// File: doc/BRIEF.md
# Mode-Selected PRG Bank Mapper

This block sits on the cartridge side of an 8-bit CPU system. It turns CPU writes in the $5000–$5FFF page into four 8-bit configuration registers. From these it builds a bank number that selects one 32 KiB slice of program ROM for the $8000–$FFFF window. The low four bits of the bank number are put together from register 0 and register 1 bits. The rule used to do this is picked by two non-adjacent bits of register 3. Register 2 supplies the four bits above them.

The block also decodes an 8 KiB work RAM at $6000–$7FFF. That RAM is never banked. On the video side it drives a fixed 8 KiB pattern RAM and applies a nametable mirroring choice that comes from a static input pin. The interrupt request output is never asserted.

The bank number is reduced modulo the number of populated banks. Smaller ROMs, including ones whose bank count is not a power of two, therefore wrap instead of reading unpopulated space.

Top module: `prgBankMapper`

## Requirements
- R1: A CPU write (cpuWr high at a rising clock edge) to any address whose bits 15:12 equal 4'h5 loads cpuWrData into the register with index cpuAddr[9:8]. So $5400, $5800 and $5C00 are aliases of register 0, and likewise for registers 1 to 3. Writes outside that page change no register.
- R2: A register write becomes visible on romAddr in the cycle after the write edge. Registers that are not addressed keep their value.
- R3: Raw bank bits 7:4 always equal register 2 bits 3:0. Register 2 bits 7:4 have no effect.
- R4: The mode is {register3[2], register3[0]}. All other register 3 bits have no effect.
- R5: In mode {0,0}, raw bank bits 3:0 = {reg0[3], reg0[2], reg1[1], 0}.
- R6: In mode {0,1}, raw bank bits 3:0 = {reg0[3], reg0[2], 0, 0}. Register 1 has no effect in this mode.
- R7: In mode {1,0}, raw bank bits 3:0 = {reg0[3], reg0[2], reg0[1], reg1[1]}.
- R8: In mode {1,1}, raw bank bits 3:0 = reg0[3:0].
- R9: Reset (rstN low) loads register 0 = 8'h03, register 3 = 8'h07 and registers 1 and 2 = 0. The first selected bank is therefore 3.
- R10: romAddr = {raw bank modulo NUM_BANKS, cpuAddr[14:0]}. romCs is high exactly when cpuRd is high and cpuAddr[15] = 1.
- R11: wramCs is high when cpuRd or cpuWr is high and cpuAddr[15:13] = 3'b011. wramWe = wramCs & cpuWr. wramAddr = cpuAddr[12:0]. wramCs and romCs are never both high.
- R12: chrCs = (ppuRd | ppuWr) & ~ppuAddr[13]. chrWe = chrCs & ppuWr. chrAddr = ppuAddr[12:0]. ntA10 = mirrorVertical ? ppuAddr[10] : ppuAddr[11].
- R13: irqN is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; register writes are taken on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | CPU address |
| cpuWrData | input | 8 | CPU write data |
| cpuWr | input | 1 | CPU write cycle |
| cpuRd | input | 1 | CPU read cycle |
| ppuAddr | input | 14 | Video bus address |
| ppuWr | input | 1 | Video bus write |
| ppuRd | input | 1 | Video bus read |
| mirrorVertical | input | 1 | Static mirroring choice: 1 vertical, 0 horizontal |
| romAddr | output | ROM_AW | Program ROM address {bank, A14:A0} |
| romCs | output | 1 | Program ROM select |
| wramCs | output | 1 | Work RAM select |
| wramWe | output | 1 | Work RAM write enable |
| wramAddr | output | 13 | Work RAM address |
| chrCs | output | 1 | Pattern RAM select |
| chrWe | output | 1 | Pattern RAM write enable |
| chrAddr | output | 13 | Pattern RAM address |
| ntA10 | output | 1 | Nametable RAM address bit 10 |
| irqN | output | 1 | Interrupt request, active low, held inactive |

## Verification
On every cycle, the assertions check that at most one register is loaded by a write and that a loaded register holds the written byte one cycle later. They also check that unaddressed registers stay stable, that the outer bank field follows register 2, that the low bank bits match the active mode's rule in modes {0,1} and {1,1}, and that the ROM and work RAM selects never overlap. Only the bench scenarios can show whether the full bank-composition rules are correct against a separately computed model. The same applies to the aliasing of the register page, the reset bank, the modulo wrap for a non-power-of-two bank count, and the register bits that must be ignored in each mode.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

  localparam int NUM_REGS = 4;
  localparam int REG_W    = 8;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int OFFS_W   = 15;   // 32 KiB window offset
  localparam int WRAM_AW  = 13;   // 8 KiB work RAM
  localparam int CHR_AW   = 13;   // 8 KiB pattern RAM
  localparam int RAW_BANK_W = 8;  // 4 outer + 4 inner bits

  // Mode selector built from register 3 bits 2 and 0
  typedef enum logic [1:0] {
    MODE_PAIR   = 2'b00,   // reg0[3:2], reg1[1] in bit 1
    MODE_QUAD   = 2'b01,   // reg0[3:2] only
    MODE_SHIFT  = 2'b10,   // reg0[3:1], reg1[1] in bit 0
    MODE_DIRECT = 2'b11    // reg0[3:0]
  } bankMode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NUM_REGS-1:0] regLoad;
    logic                romRead;
    logic                wramSel;
    logic                wramWrite;
  } ctlStrobes_t;

  function automatic logic [REG_W-1:0] resetValue(input int idx);
    case (idx)
      0:       return 8'h03;
      3:       return 8'h07;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/mapperCtrl.sv
module mapperCtrl
  import mapper_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        cpuPage,   // CPU A15:A12
  input  logic [IDX_W-1:0]  regIdx,    // CPU A9:A8
  input  logic              cpuWr,
  input  logic              cpuRd,
  output ctlStrobes_t       strobes
);

  localparam logic [3:0] REG_PAGE = 4'h5;

  logic regPageHit;
  logic wramHit;
  logic cpuActive;

  assign regPageHit = (cpuPage == REG_PAGE);
  assign wramHit    = (cpuPage[3:1] == 3'b011);
  assign cpuActive  = cpuRd | cpuWr;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_load
    assign strobes.regLoad[i] = cpuWr & regPageHit & (regIdx == IDX_W'(i));
  end

  assign strobes.romRead   = cpuRd & cpuPage[3];
  assign strobes.wramSel   = cpuActive & wramHit;
  assign strobes.wramWrite = cpuWr & wramHit;

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.regLoad)) else $error("multiple register loads"); // R1

  AST_LOAD_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.regLoad != '0) |-> (cpuWr && !strobes.wramSel && !strobes.romRead))
    else $error("register load without a write in the register page"); // R1

  AST_SEL_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.wramSel && strobes.romRead)) else $error("ROM and RAM both selected"); // R11

  AST_WE_IN_SEL: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wramWrite |-> strobes.wramSel) else $error("RAM write outside select"); // R11

endmodule

// File: rtl/mapperDatapath.sv
module mapperDatapath
  import mapper_pkg::*;
#(
  parameter int NUM_BANKS = 11,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ROM_AW = BANK_W + OFFS_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [REG_W-1:0]  cpuWrData,
  input  logic [OFFS_W-1:0] cpuOffset,
  output logic [ROM_AW-1:0] romAddr
);

  logic [REG_W-1:0]      cfgReg [NUM_REGS];
  bankMode_t             mode;
  logic [3:0]            innerBank;
  logic [RAW_BANK_W-1:0] rawBank;
  logic [BANK_W-1:0]     bankSel;

  // Configuration register file
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgReg[i] <= resetValue(i);
      end else if (strobes.regLoad[i]) begin
        cfgReg[i] <= cpuWrData;
      end
    end

    AST_REG_LOAD: assert property (@(posedge clk) disable iff (!rstN)
      strobes.regLoad[i] |=> (cfgReg[i] == $past(cpuWrData)))
      else $error("register %0d did not take write data", i); // R2

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.regLoad[i] |=> $stable(cfgReg[i]))
      else $error("register %0d changed without a write", i); // R2
  end

  // Mode from two non-adjacent bits of register 3
  assign mode = bankMode_t'({cfgReg[3][2], cfgReg[3][0]});

  always_comb begin
    case (mode)
      MODE_PAIR:   innerBank = {cfgReg[0][3:2], cfgReg[1][1], 1'b0};
      MODE_QUAD:   innerBank = {cfgReg[0][3:2], 2'b00};
      MODE_SHIFT:  innerBank = {cfgReg[0][3:1], cfgReg[1][1]};
      default:     innerBank = cfgReg[0][3:0];
    endcase
  end

  assign rawBank = {cfgReg[2][3:0], innerBank};

  // Wrap to the populated bank count
  generate
    if ((1 << BANK_W) == NUM_BANKS) begin : g_pow2
      assign bankSel = rawBank[BANK_W-1:0];
    end else begin : g_mod
      function automatic logic [BANK_W-1:0] wrapBank(input logic [RAW_BANK_W-1:0] b);
        logic [RAW_BANK_W-1:0] r;
        r = b % RAW_BANK_W'(NUM_BANKS);
        return r[BANK_W-1:0];
      endfunction
      assign bankSel = wrapBank(rawBank);
    end
  endgenerate

  assign romAddr = {bankSel, cpuOffset};

  AST_OUTER_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    rawBank[7:4] == cfgReg[2][3:0]) else $error("outer bank field mismatch"); // R3

  AST_QUAD_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReg[3][2] == 1'b0 && cfgReg[3][0] == 1'b1) |-> (rawBank[1:0] == 2'b00))
    else $error("low bank bits not clear in mode 01"); // R6

  AST_DIRECT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReg[3][2] && cfgReg[3][0]) |-> (rawBank[3:0] == cfgReg[0][3:0]))
    else $error("direct mode low bits mismatch"); // R8

endmodule

// File: rtl/ppuSide.sv
module ppuSide
  import mapper_pkg::*;
(
  input  logic [13:0]       ppuAddr,
  input  logic              ppuWr,
  input  logic              ppuRd,
  input  logic              mirrorVertical,
  output logic              chrCs,
  output logic              chrWe,
  output logic [CHR_AW-1:0] chrAddr,
  output logic              ntA10
);

  assign chrCs   = (ppuRd | ppuWr) & ~ppuAddr[13];
  assign chrWe   = chrCs & ppuWr;
  assign chrAddr = ppuAddr[CHR_AW-1:0];
  assign ntA10   = mirrorVertical ? ppuAddr[10] : ppuAddr[11];

endmodule

// File: rtl/prgBankMapper.sv
module prgBankMapper
  import mapper_pkg::*;
#(
  parameter int NUM_BANKS = 11,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ROM_AW = BANK_W + 15
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       cpuAddr,
  input  logic [7:0]        cpuWrData,
  input  logic              cpuWr,
  input  logic              cpuRd,
  input  logic [13:0]       ppuAddr,
  input  logic              ppuWr,
  input  logic              ppuRd,
  input  logic              mirrorVertical,
  output logic [ROM_AW-1:0] romAddr,
  output logic              romCs,
  output logic              wramCs,
  output logic              wramWe,
  output logic [12:0]       wramAddr,
  output logic              chrCs,
  output logic              chrWe,
  output logic [12:0]       chrAddr,
  output logic              ntA10,
  output logic              irqN
);

  ctlStrobes_t strobes;

  mapperCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cpuPage (cpuAddr[15:12]),
    .regIdx  (cpuAddr[9:8]),
    .cpuWr   (cpuWr),
    .cpuRd   (cpuRd),
    .strobes (strobes)
  );

  mapperDatapath #(.NUM_BANKS(NUM_BANKS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .cpuWrData (cpuWrData),
    .cpuOffset (cpuAddr[14:0]),
    .romAddr   (romAddr)
  );

  ppuSide u_ppu (
    .ppuAddr        (ppuAddr),
    .ppuWr          (ppuWr),
    .ppuRd          (ppuRd),
    .mirrorVertical (mirrorVertical),
    .chrCs          (chrCs),
    .chrWe          (chrWe),
    .chrAddr        (chrAddr),
    .ntA10          (ntA10)
  );

  assign romCs    = strobes.romRead;
  assign wramCs   = strobes.wramSel;
  assign wramWe   = strobes.wramWrite;
  assign wramAddr = cpuAddr[12:0];
  assign irqN     = 1'b1;

  AST_ROM_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    romCs |-> (romAddr[14:0] == cpuAddr[14:0])) else $error("ROM offset mismatch"); // R10

endmodule

// File: tb/sim_prgBankMapper.sv
`timescale 1ns/1ps
module sim_prgBankMapper;

  localparam int NB = 11;
  localparam int BW = $clog2(NB);
  localparam int AW = BW + 15;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [15:0]   cpuAddr = '0;
  logic [7:0]    cpuWrData = '0;
  logic          cpuWr = 1'b0, cpuRd = 1'b0;
  logic [13:0]   ppuAddr = '0;
  logic          ppuWr = 1'b0, ppuRd = 1'b0, mirrorVertical = 1'b0;
  logic [AW-1:0] romAddr;
  logic          romCs, wramCs, wramWe, chrCs, chrWe, ntA10, irqN;
  logic [12:0]   wramAddr, chrAddr;

  int checks = 0;
  int failures = 0;
  logic [7:0] mReg [4];

  always #2 clk = ~clk;   // 250 MHz

  prgBankMapper #(.NUM_BANKS(NB)) u0 (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuWr(cpuWr), .cpuRd(cpuRd), .ppuAddr(ppuAddr), .ppuWr(ppuWr),
    .ppuRd(ppuRd), .mirrorVertical(mirrorVertical), .romAddr(romAddr),
    .romCs(romCs), .wramCs(wramCs), .wramWe(wramWe), .wramAddr(wramAddr),
    .chrCs(chrCs), .chrWe(chrWe), .chrAddr(chrAddr), .ntA10(ntA10), .irqN(irqN)
  );

  function automatic int expBank();
    logic [3:0] lo;
    case ({mReg[3][2], mReg[3][0]})
      2'b00: lo = {mReg[0][3:2], mReg[1][1], 1'b0};
      2'b01: lo = {mReg[0][3:2], 2'b00};
      2'b10: lo = {mReg[0][3:1], mReg[1][1]};
      default: lo = mReg[0][3:0];
    endcase
    return int'({mReg[2][3:0], lo}) % NB;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpuWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuWrData = d; cpuWr = 1'b1; cpuRd = 1'b0;
    if (a[15:12] == 4'h5) mReg[a[9:8]] = d;
    @(negedge clk);
    cpuWr = 1'b0;
  endtask

  task automatic checkBank(input string req, input logic [14:0] off);
    @(negedge clk);
    cpuAddr = {1'b1, off}; cpuRd = 1'b1; cpuWr = 1'b0;
    #1;
    check(req, {romCs, romAddr}, {1'b1, BW'(expBank()), off});
    @(negedge clk);
    cpuRd = 1'b0;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd162));
    mReg[0] = 8'h03; mReg[1] = 8'h00; mReg[2] = 8'h00; mReg[3] = 8'h07;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R9 reset bank is 3
    checkBank("R9 reset bank", 15'h0000);
    check("R13 irq idle", irqN, 1);

    // R8 direct mode, R1 alias $5C00 to register 0
    cpuWrite(16'h5C00, 8'h06);
    checkBank("R1 alias 5C00 R8", 15'h1234);
    // R3 outer field, wrap 16 mod 11 (R10)
    cpuWrite(16'h5000, 8'h00);
    cpuWrite(16'h5A00, 8'hF1);   // reg2 via alias, upper bits ignored
    checkBank("R3 R10 outer wrap", 15'h7FFF);
    cpuWrite(16'h5200, 8'h00);
    // R5 mode 00 with noise bits in reg3 (R4)
    cpuWrite(16'h5300, 8'hFA);
    cpuWrite(16'h5100, 8'h02);
    checkBank("R4 R5 mode pair", 15'h0001);
    cpuWrite(16'h5000, 8'h0C);
    checkBank("R5 mode pair reg0", 15'h4000);
    // R6 reg1 ignored
    cpuWrite(16'h5300, 8'h01);
    cpuWrite(16'h5000, 8'h04);
    cpuWrite(16'h5100, 8'h02);
    checkBank("R6 reg1 ignored", 15'h0100);
    // R7 reg1 bit1 into bank bit 0
    cpuWrite(16'h5300, 8'h04);
    cpuWrite(16'h5000, 8'h00);
    checkBank("R7 shift mode", 15'h0200);
    // R2 out-of-page writes change nothing
    cpuWrite(16'h4F00, 8'h0F);
    cpuWrite(16'h6000, 8'h0F);
    checkBank("R2 R1 outside page", 15'h0300);

    // R2 write visible in the next cycle
    @(negedge clk);
    cpuAddr = 16'h5000; cpuWrData = 8'h0A; cpuWr = 1'b1; mReg[0] = 8'h0A;
    @(negedge clk);
    cpuAddr = 16'h8000; cpuWr = 1'b0; cpuRd = 1'b1;
    #1 check("R2 next cycle", romAddr, {BW'(expBank()), 15'h0000});
    @(negedge clk);
    cpuRd = 1'b0;

    // R11 work RAM decode
    @(negedge clk);
    cpuAddr = 16'h7ABC; cpuWr = 1'b1; cpuWrData = 8'h55;
    #1 check("R11 wram write", {wramCs, wramWe, romCs, wramAddr}, {3'b110, 13'h1ABC});
    cpuWr = 1'b0; cpuRd = 1'b1;
    #1 check("R11 wram read", {wramCs, wramWe, romCs}, 3'b100);
    cpuAddr = 16'h5FFF;
    #1 check("R11 no wram", {wramCs, romCs}, 2'b00);
    @(negedge clk);
    cpuRd = 1'b0;

    // R12 pattern RAM and mirroring
    ppuAddr = 14'h1F0F; ppuWr = 1'b1;
    #1 check("R12 chr write", {chrCs, chrWe, chrAddr}, {2'b11, 13'h1F0F});
    ppuWr = 1'b0; ppuRd = 1'b1; ppuAddr = 14'h2C00;
    mirrorVertical = 1'b1;
    #1 check("R12 nt vertical", {chrCs, ntA10}, 2'b01);
    ppuAddr = 14'h2800;
    #1 check("R12 nt vertical b", ntA10, 0);
    mirrorVertical = 1'b0;
    #1 check("R12 nt horizontal", ntA10, 1);
    ppuRd = 1'b0;

    // Random register traffic against the model
    for (int i = 0; i < 300; i++) begin
      logic [15:0] a;
      a = {4'h5, 12'($urandom)};
      if (($urandom % 5) == 0) a[15:12] = 4'($urandom);
      cpuWrite(a, 8'($urandom));
      checkBank("R5 R6 R7 R8 random", 15'($urandom));
    end

    // R9 reset restores bank 3
    @(negedge clk);
    rstN = 1'b0;
    mReg[0] = 8'h03; mReg[1] = 8'h00; mReg[2] = 8'h00; mReg[3] = 8'h07;
    @(negedge clk);
    rstN = 1'b1;
    checkBank("R9 re-reset", 15'h0042);
    check("R13 irq final", irqN, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule